// File: doc/BRIEF.md
# Commit-Protected GPIO Pin Configuration

This block holds the configuration of one general-purpose I/O port of eight pins and steers each pin either from its own output-data and direction bits or from one of several peripheral channels. Software reaches it through a small memory-mapped bus: writes are registered on the rising clock edge, reads return the addressed register combinationally. Per pin it stores a peripheral-select bit, a digital enable, pull-up, pull-down, open-drain and a 4-bit channel selector.

A subset of the pins is guarded. Their mode bits (peripheral select, digital enable, pull-up, pull-down) only change when a key register has been opened with a 32-bit key and the pin's commit bit is set; otherwise the written bit is dropped without notice. Which pins are guarded, which of them come out of reset already connected to a debug channel, and which channel that is, are parameters. The debug pins therefore work straight out of reset, and cannot be taken away by an unguarded write.

Top module: `gpio_cfg_port`

## Requirements
- R1: After reset the pins in DBG_MASK (default 0x0F) have peripheral-select 1, digital enable 1, pull-up 1, pull-down 0 and selector DBG_FSEL (default 1); every other pin has all of these 0; the commit register reads 1 on unguarded pins and 0 on guarded pins (default guard mask PROT_MASK = 0x8F, so it reads 0x70); the key register reads 1.
- R2: With peripheral-select 0, digital enable 1 and open-drain 0, a pin's pad_out equals its output-data bit (offset 0x000) and its pad_oe equals its direction bit (offset 0x004).
- R3: With peripheral-select 1 (register at offset 0x420), selector value k in 1..NFUNC (field bits [4p+3:4p] of offset 0x434 for pin p) connects peripheral channel k-1 of that pin, i.e. per_out/per_oe bit p*NFUNC+k-1; selector 0 or a value above NFUNC leaves the pin undriven (pad_oe 0, pad_out 0).
- R4: A pin with digital enable 0 (offset 0x424) never has pad_oe set, and its input is seen as 0 both in the input-data register (offset 0x008) and on per_in.
- R5: Registers: output data 0x000, direction 0x004, input data 0x008 (read only), peripheral-select 0x420, digital enable 0x424, pull-up 0x428, pull-down 0x42C, open-drain 0x430, selectors 0x434, key 0x438, commit 0x43C; pin p is bit p; unknown addresses read 0.
- R6: A write to a guarded pin's bit at 0x420, 0x424, 0x428 or 0x42C changes that bit only if the key register is open and the pin's commit bit is 1; unguarded pin bits always take the written value.
- R7: The commit register changes only by a write while the key register is open; its unguarded bits always read 1.
- R8: Writing exactly KEY (default 0x4C4F434B) to 0x438 opens the key register, any other value written there closes it; it reads 0 when open and 1 when closed.
- R9: An accepted write of 1 to a pin's pull-up bit clears its pull-down bit in the same cycle, and vice versa; pull-up and pull-down are never both 1 on a pin.
- R10: With open-drain 1, pad_out is 0 and pad_oe is 1 only when the selected source drives a 0.
- R11: Output data, direction, open-drain and selector fields can be written on every pin regardless of the key and commit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pad_in | input | NPINS | Level seen at each pad |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Output enable of each pad |
| pad_pu | output | NPINS | Pull-up enable of each pad |
| pad_pd | output | NPINS | Pull-down enable of each pad |
| per_out | input | NPINS*NFUNC | Peripheral output, bit p*NFUNC+c for pin p channel c |
| per_oe | input | NPINS*NFUNC | Peripheral output enable, same layout |
| per_in | output | NPINS | Pad input passed to peripherals, gated by digital enable |

## Verification
Every write is registered on the rising edge that ends its write cycle, and the stored state reaches bus_rdata and all pad outputs through combinational logic only, so each result is due one edge after the write strobe and zero edges after a change of pad_in or the peripheral inputs. The bench drives each write at a falling edge, drops the strobe at the next falling edge, and samples reads and pad outputs a little after that falling edge, so exactly one register update lies between stimulus and check. Expected register values are derived from the guard mask, the key state and the commit bits at the moment of each write.

// File: rtl/gpio_cfg_port.sv
module gpio_cfg_port #(
  parameter int NPINS = 8,
  parameter int NFUNC = 4,
  parameter int FSEL_W = 4,
  parameter logic [31:0] KEY = 32'h4C4F_434B,
  parameter logic [NPINS-1:0] PROT_MASK = 8'h8F,
  parameter logic [NPINS-1:0] DBG_MASK = 8'h0F,
  parameter logic [FSEL_W-1:0] DBG_FSEL = 4'h1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [11:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NPINS-1:0]         pad_in,
  output logic [NPINS-1:0]         pad_out,
  output logic [NPINS-1:0]         pad_oe,
  output logic [NPINS-1:0]         pad_pu,
  output logic [NPINS-1:0]         pad_pd,
  input  logic [NPINS*NFUNC-1:0]   per_out,
  input  logic [NPINS*NFUNC-1:0]   per_oe,
  output logic [NPINS-1:0]         per_in
);
  localparam int FW = NPINS * FSEL_W;
  localparam logic [11:0] A_DOUT = 12'h000;
  localparam logic [11:0] A_DIR  = 12'h004;
  localparam logic [11:0] A_DIN  = 12'h008;
  localparam logic [11:0] A_ALT  = 12'h420;
  localparam logic [11:0] A_DEN  = 12'h424;
  localparam logic [11:0] A_PU   = 12'h428;
  localparam logic [11:0] A_PD   = 12'h42C;
  localparam logic [11:0] A_OD   = 12'h430;
  localparam logic [11:0] A_FSEL = 12'h434;
  localparam logic [11:0] A_LOCK = 12'h438;
  localparam logic [11:0] A_CMT  = 12'h43C;

  function automatic logic [FW-1:0] fsel_init();
    logic [FW-1:0] r;
    r = '0;
    for (int i = 0; i < NPINS; i++)
      if (DBG_MASK[i]) r[i*FSEL_W +: FSEL_W] = DBG_FSEL;
    return r;
  endfunction

  logic [NPINS-1:0] dout_q, dir_q, alt_q, den_q, pu_q, pd_q, od_q, cmt_q;
  logic [FW-1:0]    fsel_q;
  logic             unlocked_q;

  logic [NPINS-1:0] wd, cmt_eff, wmask, set_bits;
  assign wd       = bus_wdata[NPINS-1:0];
  assign cmt_eff  = cmt_q | ~PROT_MASK;
  assign wmask    = unlocked_q ? cmt_eff : ~PROT_MASK;
  assign set_bits = wd & wmask;

  function automatic logic [NPINS-1:0] merge(logic [NPINS-1:0] old,
                                             logic [NPINS-1:0] m,
                                             logic [NPINS-1:0] d);
    return (old & ~m) | (d & m);
  endfunction

  wire wr_dout = bus_wr && bus_addr == A_DOUT;
  wire wr_dir  = bus_wr && bus_addr == A_DIR;
  wire wr_alt  = bus_wr && bus_addr == A_ALT;
  wire wr_den  = bus_wr && bus_addr == A_DEN;
  wire wr_pu   = bus_wr && bus_addr == A_PU;
  wire wr_pd   = bus_wr && bus_addr == A_PD;
  wire wr_od   = bus_wr && bus_addr == A_OD;
  wire wr_fsel = bus_wr && bus_addr == A_FSEL;
  wire wr_lock = bus_wr && bus_addr == A_LOCK;
  wire wr_cmt  = bus_wr && bus_addr == A_CMT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q     <= '0;
      dir_q      <= '0;
      od_q       <= '0;
      fsel_q     <= fsel_init();
      unlocked_q <= 1'b0;
      cmt_q      <= '0;
    end else begin
      if (wr_dout) dout_q <= wd;
      if (wr_dir)  dir_q  <= wd;
      if (wr_od)   od_q   <= wd;
      if (wr_fsel) fsel_q <= bus_wdata[FW-1:0];
      if (wr_lock) unlocked_q <= (bus_wdata == KEY);
      if (wr_cmt && unlocked_q) cmt_q <= wd & PROT_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q <= DBG_MASK;
      den_q <= DBG_MASK;
      pu_q  <= DBG_MASK;
      pd_q  <= '0;
    end else begin
      if (wr_alt) alt_q <= merge(alt_q, wmask, wd);
      if (wr_den) den_q <= merge(den_q, wmask, wd);
      if (wr_pu) begin
        pu_q <= merge(pu_q, wmask, wd);
        pd_q <= pd_q & ~set_bits;
      end else if (wr_pd) begin
        pd_q <= merge(pd_q, wmask, wd);
        pu_q <= pu_q & ~set_bits;
      end
    end
  end

  logic [NPINS-1:0] din;
  assign din    = pad_in & den_q;
  assign per_in = din;
  assign pad_pu = pu_q;
  assign pad_pd = pd_q;

  always_comb begin
    pad_out = '0;
    pad_oe  = '0;
    for (int i = 0; i < NPINS; i++) begin
      logic [FSEL_W-1:0] f;
      logic so, soe;
      f   = fsel_q[i*FSEL_W +: FSEL_W];
      so  = dout_q[i];
      soe = dir_q[i];
      if (alt_q[i]) begin
        so  = 1'b0;
        soe = 1'b0;
        for (int c = 0; c < NFUNC; c++)
          if (f == FSEL_W'(c + 1)) begin
            so  = per_out[i*NFUNC + c];
            soe = per_oe[i*NFUNC + c];
          end
      end
      if (!den_q[i]) soe = 1'b0;
      if (od_q[i]) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = soe & ~so;
      end else begin
        pad_out[i] = so;
        pad_oe[i]  = soe;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DOUT: bus_rdata[NPINS-1:0] = dout_q;
      A_DIR:  bus_rdata[NPINS-1:0] = dir_q;
      A_DIN:  bus_rdata[NPINS-1:0] = din;
      A_ALT:  bus_rdata[NPINS-1:0] = alt_q;
      A_DEN:  bus_rdata[NPINS-1:0] = den_q;
      A_PU:   bus_rdata[NPINS-1:0] = pu_q;
      A_PD:   bus_rdata[NPINS-1:0] = pd_q;
      A_OD:   bus_rdata[NPINS-1:0] = od_q;
      A_FSEL: bus_rdata = 32'(fsel_q);
      A_LOCK: bus_rdata = {31'd0, ~unlocked_q};
      A_CMT:  bus_rdata[NPINS-1:0] = cmt_eff;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_cfg_port_chk.sv
module gpio_cfg_port_chk #(
  parameter int NPINS = 8,
  parameter logic [31:0] KEY = 32'h4C4F_434B,
  parameter logic [NPINS-1:0] PROT_MASK = 8'h8F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] alt_q,
  input logic [NPINS-1:0] den_q,
  input logic [NPINS-1:0] pu_q,
  input logic [NPINS-1:0] pd_q,
  input logic [NPINS-1:0] od_q,
  input logic [NPINS-1:0] cmt_q,
  input logic             unlocked_q,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe
);
  a_r6_locked_alt_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h420 && !unlocked_q)
      |=> ((alt_q & PROT_MASK) == ($past(alt_q) & PROT_MASK)));

  a_r6_locked_den_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h424 && !unlocked_q)
      |=> ((den_q & PROT_MASK) == ($past(den_q) & PROT_MASK)));

  a_r7_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h43C && !unlocked_q) |=> $stable(cmt_q));

  a_r8_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h438 && bus_wdata == KEY) |=> unlocked_q);

  a_r8_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h438 && bus_wdata != KEY) |=> !unlocked_q);

  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_q & pd_q) == '0);

  a_r4_no_drive_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~den_q) == '0);

  a_r10_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_q) == '0);
endmodule

bind gpio_cfg_port gpio_cfg_port_chk #(
  .NPINS(NPINS), .KEY(KEY), .PROT_MASK(PROT_MASK)
) u_chk (.*);

// File: tb/sim_gpio_cfg_port.sv
module sim_gpio_cfg_port;
  localparam int NP = 8;
  localparam int NF = 4;
  localparam logic [31:0] KEY = 32'h4C4F_434B;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd, per_in;
  logic [NP*NF-1:0] per_out = '0, per_oe = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_cfg_port u0 (.*);

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    #1;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 alt", 12'h420, 32'h0F);
    rd_chk("R1 den", 12'h424, 32'h0F);
    rd_chk("R1 pu", 12'h428, 32'h0F);
    rd_chk("R1 pd", 12'h42C, 32'h00);
    rd_chk("R1 fsel", 12'h434, 32'h0000_1111);
    rd_chk("R1 commit", 12'h43C, 32'h70);
    rd_chk("R1 lock", 12'h438, 32'h1);
    rd_chk("R5 unmapped", 12'h100, 32'h0);
  endtask

  task automatic t_gpio();
    wr(12'h424, 32'hF0);
    rd_chk("R6 den unguarded taken", 12'h424, 32'h7F);
    wr(12'h000, 32'h30);
    wr(12'h004, 32'h10);
    check("R2 oe", 32'(pad_oe[6:4]), 32'h1);
    check("R2 out", 32'(pad_out[5:4]), 32'h3);
    pad_in = 8'hFF; #1;
    rd_chk("R4 din", 12'h008, 32'h7F);
    check("R4 per_in", 32'(per_in), 32'h7F);
  endtask

  task automatic t_den_off();
    wr(12'h424, 32'h00);
    rd_chk("R6 den guarded kept", 12'h424, 32'h0F);
    check("R4 oe off", 32'(pad_oe[4]), 32'h0);
    rd_chk("R4 din gated", 12'h008, 32'h0F);
  endtask

  task automatic t_alt();
    wr(12'h420, 32'h20);
    wr(12'h424, 32'h20);
    rd_chk("R6 alt", 12'h420, 32'h2F);
    wr(12'h434, 32'h0030_1111);
    per_out = '0; per_oe = '0;
    per_out[5*NF+2] = 1; per_oe[5*NF+2] = 1; per_oe[0] = 1;
    #1;
    check("R3 ch2 oe", 32'(pad_oe[5]), 32'h1);
    check("R3 ch2 out", 32'(pad_out[5]), 32'h1);
    check("R3 dbg pin0 oe", 32'(pad_oe[0]), 32'h1);
    check("R3 dbg pin0 out", 32'(pad_out[0]), 32'h0);
    wr(12'h434, 32'h0000_1111);
    check("R3 sel0 released", 32'(pad_oe[5]), 32'h0);
    wr(12'h434, 32'h0050_1111);
    check("R3 sel above range", 32'(pad_oe[5]), 32'h0);
  endtask

  task automatic t_protect();
    wr(12'h420, 32'h00);
    rd_chk("R6 locked alt", 12'h420, 32'h0F);
    wr(12'h43C, 32'hFF);
    rd_chk("R7 commit locked", 12'h43C, 32'h70);
    wr(12'h438, 32'h1234_5678);
    rd_chk("R8 wrong key", 12'h438, 32'h1);
    wr(12'h438, KEY);
    rd_chk("R8 key opens", 12'h438, 32'h0);
    wr(12'h420, 32'h00);
    rd_chk("R6 open no commit", 12'h420, 32'h0F);
    wr(12'h43C, 32'h01);
    rd_chk("R7 commit written", 12'h43C, 32'h71);
    wr(12'h420, 32'h00);
    rd_chk("R6 committed write", 12'h420, 32'h0E);
    wr(12'h438, 32'h0);
    rd_chk("R8 relock", 12'h438, 32'h1);
    wr(12'h420, 32'h0F);
    rd_chk("R6 relocked alt", 12'h420, 32'h0E);
  endtask

  task automatic t_pupd();
    wr(12'h42C, 32'h10);
    rd_chk("R9 pd set", 12'h42C, 32'h10);
    rd_chk("R9 pu after pd", 12'h428, 32'h0F);
    wr(12'h428, 32'h10);
    rd_chk("R9 pu set", 12'h428, 32'h1F);
    rd_chk("R9 pd cleared", 12'h42C, 32'h00);
    wr(12'h42C, 32'h01);
    rd_chk("R9 guarded pd dropped", 12'h42C, 32'h00);
    rd_chk("R9 guarded pu kept", 12'h428, 32'h1F);
    check("R9 pad pulls", 32'({pad_pu, pad_pd}), 32'h1F00);
  endtask

  task automatic t_od();
    wr(12'h424, 32'h10);
    wr(12'h004, 32'h10);
    wr(12'h000, 32'h10);
    wr(12'h430, 32'h11);
    rd_chk("R11 od on guarded pin", 12'h430, 32'h11);
    check("R10 high released", 32'({pad_oe[4], pad_out[4]}), 32'h0);
    wr(12'h000, 32'h00);
    check("R10 low driven", 32'({pad_oe[4], pad_out[4]}), 32'h2);
    wr(12'h434, 32'h0000_0000);
    rd_chk("R11 fsel written", 12'h434, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_gpio();
    t_den_off();
    t_alt();
    t_protect();
    t_pupd();
    t_od();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule